// File: doc/BRIEF.md
# Indexed Table Access Command Engine

This block gives a host one command port for reading and writing entries in three small internal tables: a per-instance spanning-tree port-state table, a port-isolation matrix indexed by source port, and a VLAN untag portmask table. The host first writes one or two data words. It then writes a command word that carries an execute flag, a direction flag, a table-type field and an entry index. The engine carries out the access against the selected memory and holds the execute flag high while the access is in progress. It clears that flag by itself when the access is complete, so software only has to poll that one bit.

A read copies the selected entry into the two data registers. A write commits the data registers to the selected entry. Portmask tables store only the port bits, which sit at bit 3 and upward of data word 0. Commands that name an unknown table type or an index past the table's depth take the normal time to complete and change nothing.

The host port is a plain register port with no back-pressure signal. While a command runs, every host write is dropped. Software must wait until the execute bit reads back as 0 before it writes again. Reads of the register port are combinational and are always allowed.

Top module: `tblcmd_engine`

## Requirements
- R1: After reset, busy is 0, the command, data-0 and data-1 registers read back as 0, and every entry of every table reads as zero.
- R2: The command register is at address 0. Writing it with bit 17 set starts an access. Bit 17 reads back as 1, and busy is high, for exactly one cycle after the accepting edge for a write and exactly two cycles for a read. The bit then clears by itself. The other command fields read back as written.
- R3: Bit 16 of the command word selects a write when it is 1 and a read when it is 0.
- R4: Bits 14:12 hold the table type, and bits 11:0 hold the index. Type 4 is the spanning-tree table of STP_DEPTH entries, each 64 bits wide. A write stores data-0 (address 1) as the low word and data-1 (address 2) as the high word. A read returns both words unchanged.
- R5: Type 6 is the isolation matrix of NPORTS entries, indexed by source port. Destination port d is bit d+3 of data-0. Bits 2:0 and all bits above NPORTS+2 are not stored, and a read returns them as 0, with data-1 read as 0.
- R6: Type 2 is the untag table of VLAN_DEPTH entries. It uses the same portmask layout as R5.
- R7: A command whose index is at or beyond the selected table's depth takes the normal busy time, changes no table, and leaves both data registers unchanged.
- R8: A command whose type is 0, 1, 3, 5 or 7 takes the normal busy time, changes no table, and leaves both data registers unchanged.
- R9: A host write to any register while busy is high is ignored. A new command does not start, the command readback is unchanged, and the data registers keep their values.
- R10: A command-register write with bit 17 clear is ignored. Busy stays 0, the command readback keeps its previous value, and no table changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register address: 0 command, 1 data-0, 2 data-1 |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Combinational readback of the addressed register (address 3 reads 0) |
| busy_o | output | 1 | High while a command is in progress; mirrors command bit 17 |

## Verification
The bench builds the engine with NPORTS=8, STP_DEPTH=8 and VLAN_DEPTH=16. This shrinks the tables enough for every table type from 0 to 7 to be swept across indexes 0 to 17 in both directions. The sweep reaches every in-range entry, the first few indexes past each table's end, and all five unused type codes. Because the isolation matrix is only 8 ports wide, random patterns set both the discarded low bits and the bits above the portmask, so the masking on a read becomes visible. Separate sequences inject host writes in the middle of a write command and in the middle of a read command, and issue a command with the execute bit clear.

// File: rtl/tblcmd_pkg.sv
`timescale 1ns/1ps
package tblcmd_pkg;
  localparam int unsigned CMD_EXEC_BIT = 17;
  localparam int unsigned CMD_DIR_BIT  = 16;
  localparam int unsigned CMD_TYPE_LSB = 12;
  localparam int unsigned TYPE_W       = 3;
  localparam int unsigned IDX_W        = 12;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned ENTRY_W      = 2 * WORD_W;
  localparam int unsigned NTBL         = 3;
  localparam int unsigned MASK_LSB     = 3;

  // register addresses on the host port
  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_D0  = 2'd1;
  localparam logic [1:0] ADDR_D1  = 2'd2;

  // table-type codes in the command word
  localparam logic [TYPE_W-1:0] TT_UNTAG = 3'd2;
  localparam logic [TYPE_W-1:0] TT_STP   = 3'd4;
  localparam logic [TYPE_W-1:0] TT_ISO   = 3'd6;

  // internal memory slots
  localparam logic [1:0] SLOT_STP = 2'd0;
  localparam logic [1:0] SLOT_ISO = 2'd1;
  localparam logic [1:0] SLOT_UT  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXEC   = 2'd1,
    ST_RDWAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tblcmd_ctrl.sv
`timescale 1ns/1ps
module tblcmd_ctrl
  import tblcmd_pkg::*;
#(
  parameter int unsigned STP_DEPTH = 32,
  parameter int unsigned ISO_DEPTH = 29,
  parameter int unsigned UT_DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cmd_we,
  input  logic              cmd_exec,
  input  logic              cmd_wr,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [IDX_W-1:0]  cmd_idx,
  output logic              busy_o,
  output logic              cmd_wr_o,
  output logic [TYPE_W-1:0] cmd_type_o,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [NTBL-1:0]   tbl_we_o,
  output logic [NTBL-1:0]   tbl_re_o,
  output logic              load_o,
  output logic [1:0]        load_sel_o
);
  seq_state_t        state_q, state_d;
  logic              cmd_wr_q;
  logic [TYPE_W-1:0] cmd_type_q;
  logic [IDX_W-1:0]  cmd_idx_q;
  logic              hit_q;
  logic [1:0]        sel_q;
  logic [1:0]        tsel;
  logic              hit;
  logic              accept;

  assign busy_o     = (state_q != ST_IDLE);
  assign accept     = host_cmd_we && cmd_exec && (state_q == ST_IDLE);
  assign cmd_wr_o   = cmd_wr_q;
  assign cmd_type_o = cmd_type_q;
  assign cmd_idx_o  = cmd_idx_q;

  // type decode and range check
  always_comb begin
    tsel = SLOT_STP;
    hit  = 1'b0;
    case (cmd_type_q)
      TT_STP: begin
        tsel = SLOT_STP;
        hit  = 32'(cmd_idx_q) < STP_DEPTH;
      end
      TT_ISO: begin
        tsel = SLOT_ISO;
        hit  = 32'(cmd_idx_q) < ISO_DEPTH;
      end
      TT_UNTAG: begin
        tsel = SLOT_UT;
        hit  = 32'(cmd_idx_q) < UT_DEPTH;
      end
      default: begin
        tsel = SLOT_STP;
        hit  = 1'b0;
      end
    endcase
  end

  always_comb begin
    tbl_we_o = '0;
    tbl_re_o = '0;
    state_d  = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_EXEC;
      ST_EXEC: begin
        if (cmd_wr_q) begin
          tbl_we_o[tsel] = hit;
          state_d        = ST_IDLE;
        end else begin
          tbl_re_o[tsel] = hit;
          state_d        = ST_RDWAIT;
        end
      end
      ST_RDWAIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign load_o     = (state_q == ST_RDWAIT) && hit_q;
  assign load_sel_o = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cmd_wr_q   <= 1'b0;
      cmd_type_q <= '0;
      cmd_idx_q  <= '0;
      hit_q      <= 1'b0;
      sel_q      <= SLOT_STP;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cmd_wr_q   <= cmd_wr;
        cmd_type_q <= cmd_type;
        cmd_idx_q  <= cmd_idx;
      end
      if (state_q == ST_EXEC) begin
        hit_q <= hit && !cmd_wr_q;
        sel_q <= tsel;
      end
    end
  end

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && host_cmd_we) |=> ($stable(cmd_idx_q) && $stable(cmd_type_q) && $stable(cmd_wr_q)));

  // R2
  wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && cmd_wr_q) |=> !busy_o);

  // R2
  rd_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && !cmd_wr_q) |=> busy_o ##1 !busy_o);

  // R10
  no_exec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && host_cmd_we && !cmd_exec) |=> !busy_o);
endmodule

// File: rtl/tblcmd_mem.sv
`timescale 1ns/1ps
module tblcmd_mem
  import tblcmd_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    addr;

  assign addr = idx_i[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[addr] <= wdata_i;
      if (re_i) rdata_o <= mem_q[addr];
    end
  end

  // R7
  we_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i || re_i) |-> (32'(idx_i) < DEPTH));

  // R3
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && re_i));
endmodule

// File: rtl/tblcmd_engine.sv
`timescale 1ns/1ps
module tblcmd_engine
  import tblcmd_pkg::*;
#(
  parameter int unsigned NPORTS     = 29,
  parameter int unsigned STP_DEPTH  = 32,
  parameter int unsigned VLAN_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy_o
);
  localparam int unsigned T_DEPTH [NTBL] = '{STP_DEPTH, NPORTS, VLAN_DEPTH};
  localparam int unsigned T_WIDTH [NTBL] = '{ENTRY_W, NPORTS, NPORTS};
  localparam int unsigned T_LSB   [NTBL] = '{0, MASK_LSB, MASK_LSB};

  logic [WORD_W-1:0]  dreg0_q, dreg1_q;
  logic [ENTRY_W-1:0] wr_word;
  logic [ENTRY_W-1:0] rd_full [NTBL];
  logic [NTBL-1:0]    tbl_we, tbl_re;
  logic               load;
  logic [1:0]         load_sel;
  logic               cmd_wr_q;
  logic [TYPE_W-1:0]  cmd_type_q;
  logic [IDX_W-1:0]   cmd_idx_q;
  logic               host_cmd_we;
  logic [ENTRY_W-1:0] load_word;

  assign host_cmd_we = reg_we && (reg_addr == ADDR_CMD);
  assign wr_word     = {dreg1_q, dreg0_q};

  tblcmd_ctrl #(
    .STP_DEPTH(STP_DEPTH),
    .ISO_DEPTH(NPORTS),
    .UT_DEPTH (VLAN_DEPTH)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cmd_we(host_cmd_we),
    .cmd_exec   (reg_wdata[CMD_EXEC_BIT]),
    .cmd_wr     (reg_wdata[CMD_DIR_BIT]),
    .cmd_type   (reg_wdata[CMD_TYPE_LSB +: TYPE_W]),
    .cmd_idx    (reg_wdata[IDX_W-1:0]),
    .busy_o     (busy_o),
    .cmd_wr_o   (cmd_wr_q),
    .cmd_type_o (cmd_type_q),
    .cmd_idx_o  (cmd_idx_q),
    .tbl_we_o   (tbl_we),
    .tbl_re_o   (tbl_re),
    .load_o     (load),
    .load_sel_o (load_sel)
  );

  for (genvar t = 0; t < int'(NTBL); t++) begin : g_tbl
    localparam int unsigned W = T_WIDTH[t];
    localparam int unsigned L = T_LSB[t];
    logic [W-1:0] q;

    tblcmd_mem #(
      .DEPTH(T_DEPTH[t]),
      .WIDTH(W)
    ) mem_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (tbl_we[t]),
      .re_i   (tbl_re[t]),
      .idx_i  (cmd_idx_q),
      .wdata_i(wr_word[L +: W]),
      .rdata_o(q)
    );

    assign rd_full[t] = ENTRY_W'(q) << L;
  end

  always_comb begin
    load_word = rd_full[SLOT_STP];
    if (load_sel == SLOT_ISO) load_word = rd_full[SLOT_ISO];
    if (load_sel == SLOT_UT)  load_word = rd_full[SLOT_UT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg0_q <= '0;
      dreg1_q <= '0;
    end else if (load) begin
      dreg0_q <= load_word[WORD_W-1:0];
      dreg1_q <= load_word[ENTRY_W-1:WORD_W];
    end else if (reg_we && !busy_o) begin
      if (reg_addr == ADDR_D0) dreg0_q <= reg_wdata;
      if (reg_addr == ADDR_D1) dreg1_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CMD: begin
        reg_rdata[CMD_EXEC_BIT]                = busy_o;
        reg_rdata[CMD_DIR_BIT]                 = cmd_wr_q;
        reg_rdata[CMD_TYPE_LSB +: TYPE_W]      = cmd_type_q;
        reg_rdata[IDX_W-1:0]                   = cmd_idx_q;
      end
      ADDR_D0: reg_rdata = dreg0_q;
      ADDR_D1: reg_rdata = dreg1_q;
      default: reg_rdata = '0;
    endcase
  end

  // R9
  data_hold_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> ($stable(dreg0_q) && $stable(dreg1_q)));

  // R4
  one_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tbl_we, tbl_re}));

  // R2
  access_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{tbl_we, tbl_re}) |-> busy_o);
endmodule

// File: tb/tblcmd_engine_tb_top.sv
`timescale 1ns/1ps
module tblcmd_engine_tb_top;
  localparam int NP = 8;
  localparam int SD = 8;
  localparam int VD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        busy_o;

  int nchk = 0;
  int nfail = 0;

  logic [31:0] m_stp0 [SD];
  logic [31:0] m_stp1 [SD];
  logic [NP-1:0] m_iso [NP];
  logic [NP-1:0] m_ut  [VD];

  always #5 clk = ~clk;

  tblcmd_engine #(.NPORTS(NP), .STP_DEPTH(SD), .VLAN_DEPTH(VD)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_o(busy_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input logic ex, input logic wr, input int typ, input int idx);
    return {14'd0, ex, wr, 1'b0, 3'(typ), 12'(idx)};
  endfunction

  function automatic bit valid_e(input int typ, input int idx);
    return (typ == 4 && idx < SD) || (typ == 6 && idx < NP) || (typ == 2 && idx < VD);
  endfunction

  function automatic string req_of(input int typ, input int idx);
    if (!(typ == 2 || typ == 4 || typ == 6)) return "R8";
    if (!valid_e(typ, idx)) return "R7";
    if (typ == 4) return "R4";
    if (typ == 6) return "R5";
    return "R6";
  endfunction

  task automatic hw(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // issues a command and checks the busy window (R2, R3)
  task automatic do_cmd(input logic wr, input int typ, input int idx);
    logic [31:0] v;
    hw(2'd0, cmdw(1'b1, wr, typ, idx));
    chk("R2", "busy after accept", 64'(busy_o), 64'd1);
    rd(2'd0, v);
    chk("R2", "exec bit while busy", 64'(v[17]), 64'd1);
    @(negedge clk);
    if (wr) begin
      chk("R3", "write busy done", 64'(busy_o), 64'd0);
    end else begin
      chk("R3", "read busy 2nd cycle", 64'(busy_o), 64'd1);
      @(negedge clk);
      chk("R3", "read busy done", 64'(busy_o), 64'd0);
    end
    rd(2'd0, v);
    chk("R2", "cmd readback", 64'(v), 64'(cmdw(1'b0, wr, typ, idx)));
  endtask

  task automatic write_entry(input int typ, input int idx, input logic [31:0] w0, input logic [31:0] w1);
    hw(2'd1, w0);
    hw(2'd2, w1);
    do_cmd(1'b1, typ, idx);
    if (valid_e(typ, idx)) begin
      if (typ == 4) begin m_stp0[idx] = w0; m_stp1[idx] = w1; end
      else if (typ == 6) m_iso[idx] = w0[NP+2:3];
      else m_ut[idx] = w0[NP+2:3];
    end
  endtask

  task automatic read_sweep();
    logic [31:0] s0, s1, d0, d1, e0, e1;
    for (int typ = 0; typ < 8; typ++) begin
      for (int idx = 0; idx < 18; idx++) begin
        s0 = 32'hC0DE0000 | 32'(typ * 256 + idx);
        s1 = ~s0;
        hw(2'd1, s0);
        hw(2'd2, s1);
        do_cmd(1'b0, typ, idx);
        rd(2'd1, d0);
        rd(2'd2, d1);
        e0 = s0; e1 = s1;
        if (valid_e(typ, idx)) begin
          if (typ == 4) begin e0 = m_stp0[idx]; e1 = m_stp1[idx]; end
          else if (typ == 6) begin e0 = 32'(m_iso[idx]) << 3; e1 = 32'd0; end
          else begin e0 = 32'(m_ut[idx]) << 3; e1 = 32'd0; end
        end
        chk(req_of(typ, idx), $sformatf("t%0d i%0d word0", typ, idx), 64'(d0), 64'(e0));
        chk(req_of(typ, idx), $sformatf("t%0d i%0d word1", typ, idx), 64'(d1), 64'(e1));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v, p0, p1;
    for (int i = 0; i < SD; i++) begin m_stp0[i] = '0; m_stp1[i] = '0; end
    for (int i = 0; i < NP; i++) m_iso[i] = '0;
    for (int i = 0; i < VD; i++) m_ut[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 64'(busy_o), 64'd0);
    rd(2'd0, v); chk("R1", "cmd reg", 64'(v), 64'd0);
    rd(2'd1, v); chk("R1", "data0 reg", 64'(v), 64'd0);
    rd(2'd2, v); chk("R1", "data1 reg", 64'(v), 64'd0);
    read_sweep();   // R1: all entries zero

    // writes across all types and indexes, including unused codes and overruns
    for (int typ = 0; typ < 8; typ++) begin
      for (int idx = 0; idx < 18; idx++) begin
        p0 = 32'h9E3779B9 * 32'(typ * 64 + idx + 1);
        p1 = 32'h7F4A7C15 ^ (p0 << 1);
        write_entry(typ, idx, p0, p1);
      end
    end
    read_sweep();

    // R9: data write during a write command
    hw(2'd1, 32'h1111_2222);
    hw(2'd2, 32'h3333_4444);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = cmdw(1'b1, 1'b1, 4, 0);
    @(negedge clk); reg_addr = 2'd1; reg_wdata = 32'hBAD0_0001;
    @(negedge clk); reg_we = 1'b0;
    m_stp0[0] = 32'h1111_2222; m_stp1[0] = 32'h3333_4444;
    rd(2'd1, v); chk("R9", "data0 kept", 64'(v), 64'h1111_2222);

    // R9: new command and data write during a read command
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = cmdw(1'b1, 1'b0, 4, 1);
    @(negedge clk); reg_wdata = cmdw(1'b1, 1'b1, 4, 2);
    @(negedge clk); reg_addr = 2'd2; reg_wdata = 32'hBAD0_0002;
    @(negedge clk); reg_we = 1'b0;
    chk("R9", "busy clear", 64'(busy_o), 64'd0);
    rd(2'd0, v); chk("R9", "cmd kept", 64'(v), 64'(cmdw(1'b0, 1'b0, 4, 1)));
    rd(2'd1, v); chk("R9", "read data0", 64'(v), 64'(m_stp0[1]));
    rd(2'd2, v); chk("R9", "read data1", 64'(v), 64'(m_stp1[1]));
    do_cmd(1'b0, 4, 2);
    rd(2'd1, v); chk("R9", "entry 2 untouched", 64'(v), 64'(m_stp0[2]));
    do_cmd(1'b0, 4, 0);
    rd(2'd2, v); chk("R9", "entry 0 written", 64'(v), 64'h3333_4444);

    // R10: command with execute clear
    hw(2'd1, 32'h5555_6666);
    hw(2'd0, cmdw(1'b0, 1'b1, 4, 3));
    chk("R10", "no busy", 64'(busy_o), 64'd0);
    rd(2'd0, v); chk("R10", "cmd kept", 64'(v), 64'(cmdw(1'b0, 1'b0, 4, 0)));
    do_cmd(1'b0, 4, 3);
    rd(2'd1, v); chk("R10", "entry 3 untouched", 64'(v), 64'(m_stp0[3]));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule